// File: doc/BRIEF.md
# Video RAM Block-Copy DMA Engine

The engine moves data from the system address space into an 8 KiB video memory window in 16-byte units. Software programs a source pointer and a destination pointer through four byte-wide address registers. It then writes a control byte. The control byte picks one of two modes and gives a length of 1 to 128 units.

In immediate mode the whole length is copied at once, and `stall_o` holds the processor off until the copy ends. In blanking mode one unit is copied per `hblank_i` pulse, which an external video timing block supplies, until the length is used up. The control register read value shows whether a transfer is pending and how many units remain. The pointers are aligned on entry, a source inside the video window is refused, and the advanced pointers are written back into the address registers after every run.

Top module: `vram_dma`

## Requirements
- R1: The source pointer is {source-high, source-low} with bits 3:0 cleared. If the unaligned source has bits 15:13 equal to 3'b100 (0x8000–0x9FFF), a control write is refused: no bytes move, `stall_o` stays low and the control read value is unchanged.
- R2: The destination offset on `vram_addr_o` is {dest-high, dest-low} AND 0x1FF0. It increments by one per byte and wraps from 0x1FFF to 0x0000.
- R3: A control write with bit 7 = 0, made while no blanking transfer is armed, starts an immediate transfer of ((value AND 0x7F)+1)×16 bytes. Source bytes go in ascending order to ascending destination offsets.
- R4: A control write with bit 7 = 1 arms blanking mode and moves nothing. Each `hblank_i` pulse seen while the engine is armed and idle copies exactly 16 bytes. Pulses at any other time have no effect.
- R5: Each byte takes 2 cycles: one cycle with `src_rd_o` high, then one cycle with `vram_we_o` high that carries the data returned on `src_rdata_i`. `stall_o` is high for the whole run, so an immediate run of N units stalls 32×N cycles.
- R6: At the end of every run, the source registers read the next source address. The destination registers read 0x80|offset[12:8] and offset[7:0] of the next destination.
- R7: Control reads as {done, remaining}. Bit 7 is 0 while a transfer is pending, and the 7-bit count drops by one per completed unit. After the last unit, and after reset, it reads 0xFF.
- R8: A control write with bit 7 = 0 while blanking mode is armed and idle cancels it. Control then reads {1, remaining}, and later pulses move nothing.
- R9: Control writes made while bytes are moving are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control; 5–7 read 0xFF |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read value of the selected register (combinational) |
| hblank_i | input | 1 | One-cycle horizontal blank pulse |
| src_rd_o | output | 1 | Source read request |
| src_addr_o | output | 16 | Source byte address |
| src_rdata_i | input | 8 | Source data, valid the cycle after the request |
| vram_we_o | output | 1 | Video memory write strobe |
| vram_addr_o | output | 13 | Video memory byte offset |
| vram_wdata_o | output | 8 | Video memory write data |
| stall_o | output | 1 | High while bytes are moving |

## Verification
A control write or an `hblank_i` pulse is sampled at a rising edge. The first `src_rd_o` appears in the following cycle, and the matching `vram_we_o` comes one cycle after that, so `stall_o` rises one edge after the stimulus. Register writeback and the new control read value are visible once `stall_o` falls. The bench samples at falling edges only. A monitor pops expected (offset, data) pairs from a queue on every write strobe. Stall length is counted in falling edges from the first one after the stimulus. Register reads are taken only after the stall has fallen.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;
  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/vdma_cfg_decode.sv
module vdma_cfg_decode #(
  parameter int ADDR_W   = 16,
  parameter int VRAM_AW  = 13,
  parameter int UNIT_LG  = 4,
  parameter int VRAM_TAG = 4
) (
  input  logic [ADDR_W-1:0]  src_raw_i,
  input  logic [ADDR_W-1:0]  dst_raw_i,
  output logic [ADDR_W-1:0]  src_al_o,
  output logic [VRAM_AW-1:0] dst_off_o,
  output logic               reject_o
);
  localparam int TAG_W = ADDR_W - VRAM_AW;

  assign src_al_o  = {src_raw_i[ADDR_W-1:UNIT_LG], {UNIT_LG{1'b0}}};
  assign dst_off_o = {dst_raw_i[VRAM_AW-1:UNIT_LG], {UNIT_LG{1'b0}}};
  assign reject_o  = (src_raw_i[ADDR_W-1:VRAM_AW] == TAG_W'(VRAM_TAG));
endmodule

// File: rtl/vdma_addr_regs.sv
module vdma_addr_regs #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int VRAM_AW  = 13,
  parameter int UNIT_LG  = 4,
  parameter int VRAM_TAG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wb_valid_i,
  input  logic [ADDR_W-1:0]  wb_src_i,
  input  logic [VRAM_AW-1:0] wb_dst_off_i,
  output logic [ADDR_W-1:0]  src_raw_o,
  output logic [ADDR_W-1:0]  dst_raw_o,
  output logic [DATA_W-1:0]  rd_byte_o
);
  localparam int NREG  = 4;
  localparam int TAG_W = ADDR_W - VRAM_AW;

  logic [DATA_W-1:0] byte_q  [NREG];
  logic [DATA_W-1:0] wb_byte [NREG];
  logic [ADDR_W-1:0] wb_dst_full;

  assign wb_dst_full = {TAG_W'(VRAM_TAG), wb_dst_off_i};
  assign wb_byte[0]  = wb_src_i[ADDR_W-1:DATA_W];
  assign wb_byte[1]  = wb_src_i[DATA_W-1:0];
  assign wb_byte[2]  = wb_dst_full[ADDR_W-1:DATA_W];
  assign wb_byte[3]  = wb_dst_full[DATA_W-1:0];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               byte_q[gi] <= '0;
      else if (wb_valid_i)                       byte_q[gi] <= wb_byte[gi];
      else if (we_i && sel_i == 3'(gi))          byte_q[gi] <= wdata_i;
    end
  end

  assign src_raw_o = {byte_q[0], byte_q[1]};
  assign dst_raw_o = {byte_q[2], byte_q[3]};
  assign rd_byte_o = byte_q[sel_i[1:0]];

  AST_WB_SRC_UNIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |-> wb_src_i[UNIT_LG-1:0] == '0); // R6
  AST_WB_DST_UNIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |-> wb_dst_off_i[UNIT_LG-1:0] == '0); // R2
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int VRAM_AW = 13,
  parameter int UNIT_LG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [DATA_W-1:0]  ctrl_wdata_i,
  input  logic               reject_i,
  input  logic [ADDR_W-1:0]  src_al_i,
  input  logic [VRAM_AW-1:0] dst_off_i,
  input  logic               hblank_i,
  output logic               src_rd_o,
  output logic [ADDR_W-1:0]  src_addr_o,
  input  logic [DATA_W-1:0]  src_rdata_i,
  output logic               vram_we_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic [DATA_W-1:0]  vram_wdata_o,
  output logic               stall_o,
  output logic [DATA_W-1:0]  ctrl_rd_o,
  output logic               wb_valid_o,
  output logic [ADDR_W-1:0]  wb_src_o,
  output logic [VRAM_AW-1:0] wb_dst_off_o
);
  localparam int LEN_W = DATA_W - 1;

  eng_state_e         state_q;
  logic               hb_armed_q, done_q;
  logic [LEN_W-1:0]   len_q;
  logic [UNIT_LG-1:0] byte_q;
  logic [ADDR_W-1:0]  src_q;
  logic [VRAM_AW-1:0] dst_q;

  logic idle, last_byte, start_ok, go_hb, go_gen, go_cancel, go_unit;

  assign idle      = (state_q == ST_IDLE);
  assign last_byte = (state_q == ST_WR) && (byte_q == '1);
  assign start_ok  = ctrl_we_i && idle && !reject_i;
  assign go_hb     = start_ok && ctrl_wdata_i[DATA_W-1];
  assign go_cancel = start_ok && !ctrl_wdata_i[DATA_W-1] && hb_armed_q;
  assign go_gen    = start_ok && !ctrl_wdata_i[DATA_W-1] && !hb_armed_q;
  assign go_unit   = idle && hb_armed_q && hblank_i && !start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      hb_armed_q <= 1'b0;
      done_q     <= 1'b1;
      len_q      <= '1;
      byte_q     <= '0;
      src_q      <= '0;
      dst_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go_hb || go_gen) begin
            src_q      <= src_al_i;
            dst_q      <= dst_off_i;
            len_q      <= ctrl_wdata_i[LEN_W-1:0];
            done_q     <= 1'b0;
            byte_q     <= '0;
            hb_armed_q <= go_hb;
            if (go_gen) state_q <= ST_RD;
          end else if (go_cancel) begin
            hb_armed_q <= 1'b0;
            done_q     <= 1'b1;
          end else if (go_unit) begin
            byte_q  <= '0;
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          src_q  <= src_q + 1'b1;
          dst_q  <= dst_q + 1'b1;   // wraps inside the video window
          byte_q <= byte_q + 1'b1;
          if (last_byte) begin
            if (len_q == '0) begin
              done_q     <= 1'b1;
              len_q      <= '1;
              hb_armed_q <= 1'b0;
              state_q    <= ST_IDLE;
            end else begin
              len_q   <= len_q - 1'b1;
              state_q <= hb_armed_q ? ST_IDLE : ST_RD;
            end
          end else begin
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_rd_o     = (state_q == ST_RD);
  assign src_addr_o   = src_q;
  assign vram_we_o    = (state_q == ST_WR);
  assign vram_addr_o  = dst_q;
  assign vram_wdata_o = src_rdata_i;
  assign stall_o      = !idle;
  assign ctrl_rd_o    = {done_q, len_q};
  assign wb_valid_o   = last_byte;
  assign wb_src_o     = src_q + 1'b1;
  assign wb_dst_off_o = dst_q + 1'b1;

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_rd_o |=> vram_we_o && $stable(vram_addr_o)); // R5
  AST_RUN_START_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rd_o && byte_q == '0) |-> (src_addr_o[UNIT_LG-1:0] == '0 && vram_addr_o[UNIT_LG-1:0] == '0)); // R1
  AST_DONE_READS_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) && !$past(hb_armed_q && idle) |-> len_q == '1); // R7
  AST_HB_SINGLE_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_armed_q && last_byte) |=> !stall_o); // R4
  AST_BUSY_IGNORES_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && stall_o && !last_byte) |=> $stable(len_q) && $stable(done_q)); // R9
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int VRAM_AW  = 13,
  parameter int UNIT_LG  = 4,
  parameter int VRAM_TAG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               hblank_i,
  output logic               src_rd_o,
  output logic [ADDR_W-1:0]  src_addr_o,
  input  logic [DATA_W-1:0]  src_rdata_i,
  output logic               vram_we_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic [DATA_W-1:0]  vram_wdata_o,
  output logic               stall_o
);
  logic [ADDR_W-1:0]  src_raw, dst_raw, src_al, wb_src;
  logic [VRAM_AW-1:0] dst_off, wb_dst_off;
  logic [DATA_W-1:0]  addr_rd, ctrl_rd;
  logic               reject, wb_valid, ctrl_we, addr_we;

  assign ctrl_we = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign addr_we = reg_we_i && !reg_sel_i[2];

  vdma_cfg_decode #(
    .ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW), .UNIT_LG(UNIT_LG), .VRAM_TAG(VRAM_TAG)
  ) u_decode (
    .src_raw_i(src_raw), .dst_raw_i(dst_raw),
    .src_al_o(src_al), .dst_off_o(dst_off), .reject_o(reject)
  );

  vdma_addr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VRAM_AW(VRAM_AW),
    .UNIT_LG(UNIT_LG), .VRAM_TAG(VRAM_TAG)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(addr_we), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .wb_valid_i(wb_valid), .wb_src_i(wb_src),
    .wb_dst_off_i(wb_dst_off), .src_raw_o(src_raw), .dst_raw_o(dst_raw),
    .rd_byte_o(addr_rd)
  );

  vdma_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VRAM_AW(VRAM_AW), .UNIT_LG(UNIT_LG)
  ) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we),
    .ctrl_wdata_i(reg_wdata_i), .reject_i(reject), .src_al_i(src_al),
    .dst_off_i(dst_off), .hblank_i(hblank_i), .src_rd_o(src_rd_o),
    .src_addr_o(src_addr_o), .src_rdata_i(src_rdata_i), .vram_we_o(vram_we_o),
    .vram_addr_o(vram_addr_o), .vram_wdata_o(vram_wdata_o), .stall_o(stall_o),
    .ctrl_rd_o(ctrl_rd), .wb_valid_o(wb_valid), .wb_src_o(wb_src),
    .wb_dst_off_o(wb_dst_off)
  );

  always_comb begin
    if (reg_sel_i == SEL_CTRL) reg_rdata_o = ctrl_rd;
    else if (!reg_sel_i[2])    reg_rdata_o = addr_rd;
    else                       reg_rdata_o = '1;
  end

  AST_NO_VRAM_SOURCE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && reject) |=> !stall_o); // R1
endmodule

// File: tb/vram_dma_tb.sv
module vram_dma_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, hblank = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0, reg_rdata, src_rdata = 8'd0, vram_wdata;
  logic        src_rd, vram_we, stall;
  logic [15:0] src_addr;
  logic [12:0] vram_addr;

  int checks = 0, failures = 0;
  logic [20:0] exp_q[$];

  always #2 clk = ~clk;

  vram_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hblank_i(hblank),
    .src_rd_o(src_rd), .src_addr_o(src_addr), .src_rdata_i(src_rdata),
    .vram_we_o(vram_we), .vram_addr_o(vram_addr), .vram_wdata_o(vram_wdata),
    .stall_o(stall)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] + (a[15:8] * 8'd7) + 8'h5A;
  endfunction

  // source memory model, one cycle read latency
  always @(posedge clk) if (src_rd) src_rdata <= pat(src_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every video write must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && vram_we) begin
      logic [20:0] e;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 actual=%0h expected=none", {vram_addr, vram_wdata});
      end else begin
        e = exp_q.pop_front();
        chk("R2/R3 write", {11'd0, vram_addr, vram_wdata}, {11'd0, e});
      end
    end
  end

  task automatic push_run(input logic [15:0] src, input logic [12:0] dst, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] s;
      logic [12:0] d;
      s = src + 16'(i);
      d = dst + 13'(i);
      exp_q.push_back({d, pat(s)});
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
    wr(3'd0, s[15:8]); wr(3'd1, s[7:0]); wr(3'd2, d[15:8]); wr(3'd3, d[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd4, v); chk("R7 reset ctrl", v, 8'hFF);
    chk("R5 reset stall", stall, 1'b0);

    // immediate run, 2 units
    set_ptrs(16'h1234, 16'hC567);
    push_run(16'h1230, 13'h0560, 32);
    wr(3'd4, 8'h01);
    count_stall(n); chk("R5 stall cycles", n, 64);
    rd(3'd4, v); chk("R7 done ctrl", v, 8'hFF);
    rd(3'd0, v); chk("R6 src hi", v, 8'h12);
    rd(3'd1, v); chk("R6 src lo", v, 8'h50);
    rd(3'd2, v); chk("R6 dst hi", v, 8'h85);
    rd(3'd3, v); chk("R6 dst lo", v, 8'h80);
    chk("R3 all written", exp_q.size(), 0);

    // refused source inside video window
    set_ptrs(16'h9A00, 16'h0000);
    wr(3'd4, 8'h00);
    chk("R1 no stall", stall, 1'b0);
    repeat (4) @(negedge clk);
    chk("R1 still idle", stall, 1'b0);
    rd(3'd4, v); chk("R1 ctrl unchanged", v, 8'hFF);

    // destination wraps at end of window
    set_ptrs(16'h2000, 16'h1FF0);
    push_run(16'h2000, 13'h1FF0, 32);
    wr(3'd4, 8'h01);
    count_stall(n); chk("R2 wrap stall", n, 64);
    rd(3'd2, v); chk("R2 wrapped dst hi", v, 8'h80);
    rd(3'd3, v); chk("R2 wrapped dst lo", v, 8'h10);
    rd(3'd1, v); chk("R6 src lo after wrap", v, 8'h20);

    // blanking mode, 3 units
    set_ptrs(16'h4000, 16'h0000);
    wr(3'd4, 8'h82);
    rd(3'd4, v); chk("R7 armed ctrl", v, 8'h02);
    repeat (3) @(negedge clk);
    chk("R4 armed no move", stall, 1'b0);
    push_run(16'h4000, 13'h0000, 16);
    pulse();
    count_stall(n); chk("R4 unit cycles", n, 32);
    rd(3'd4, v); chk("R7 after unit1", v, 8'h01);
    rd(3'd1, v); chk("R6 src lo unit1", v, 8'h10);
    rd(3'd3, v); chk("R6 dst lo unit1", v, 8'h10);
    push_run(16'h4010, 13'h0010, 16);
    pulse();
    wr(3'd4, 8'h00);                 // lands while moving
    count_stall(n);
    rd(3'd4, v); chk("R9 busy write ignored", v, 8'h00);
    push_run(16'h4020, 13'h0020, 16);
    pulse();
    count_stall(n); chk("R4 unit3 cycles", n, 32);
    rd(3'd4, v); chk("R7 blank done", v, 8'hFF);
    pulse();
    chk("R4 extra pulse ignored", stall, 1'b0);
    chk("R4 queue drained", exp_q.size(), 0);

    // cancel armed blanking transfer
    set_ptrs(16'h5000, 16'h0100);
    wr(3'd4, 8'h85);
    rd(3'd4, v); chk("R7 armed 6 units", v, 8'h05);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R8 cancel ctrl", v, 8'h85);
    pulse();
    chk("R8 pulse after cancel", stall, 1'b0);

    // immediate run after cancel, 1 unit
    push_run(16'h5000, 13'h0100, 16);
    wr(3'd4, 8'h00);
    count_stall(n); chk("R3 single unit cycles", n, 32);
    rd(3'd4, v); chk("R7 done again", v, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R3 final queue", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule